// File: doc/BRIEF.md
# Chip-Select Gated Registered Buffer

This block is a 1:2 fan-out register for the address and command lanes of a memory module. On every rising clock edge it captures a 28-bit data word and two chip-select lines. Each captured bit then drives two output copies, so a single input pin can serve two banks of loads.

A static configuration input selects one of two lane maps for the second copy. In map A the second copy is identical to the first. In map B the second copy carries the two halves of the word exchanged. A low-power active mode freezes both data copies at any edge where the gate-enable input and both chip selects are sampled high. The chip-select outputs keep updating in that mode.

An asynchronous active-low reset clears every register at once and has priority over the gating.

Top module: `rbuf_gated_fanout`

## Requirements
- R1: While `rstN` is low, `qA`, `qB`, `csQA` and `csQB` are all zero, and this takes effect at once, without waiting for a clock edge.
- R2: With gating inactive, `qA` shows the `dIn` value sampled at the most recent rising edge of `clk`, and it does not change between edges when `dIn` changes.
- R3: `qA[i]` always equals bit i of the captured word, in both lane maps.
- R4: With `cfgSel` = 0 (map A), `qB` equals `qA`.
- R5: With `cfgSel` = 1 (map B), `qB[i]` equals captured bit `(i+14) mod 28`, so the two 14-bit halves are exchanged.
- R6: At a rising edge where `gateEn`, `csIn[0]` and `csIn[1]` are all 1, the captured word is not updated, and `qA` and `qB` keep their previous values.
- R7: At a rising edge where any one of `gateEn`, `csIn[0]` or `csIn[1]` is 0, the captured word loads `dIn`.
- R8: `csQA` and `csQB` both show the `csIn` value sampled at the latest rising edge (bit 0 is chip select 0), including at edges where the data is held.
- R9: Reset overrides the gating. Holding reset across an edge while all three gating inputs are 1 still leaves the outputs zero. After release, the outputs stay zero until an edge loads data.
- R10: The gating decision uses the chip-select values sampled at the same edge. When both chip selects rise to 1 at an edge while `gateEn` is 1, the data offered at that edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSel | input | 1 | Lane map select: 0 = map A, 1 = map B (static) |
| gateEn | input | 1 | Enables chip-select based output freezing |
| csIn | input | 2 | Chip select lines 1 and 0, active low at the memory |
| dIn | input | 28 | Data word to register |
| qA | output | 28 | First output copy |
| qB | output | 28 | Second output copy, lane-mapped by `cfgSel` |
| csQA | output | 2 | Registered chip selects, first copy |
| csQB | output | 2 | Registered chip selects, second copy |

## Verification
The hardest situation to produce is the interaction of reset with the gating. It needs a reset that lands in the middle of a clock phase, held across an edge while all three gating inputs are high, and then released with gating still active, so that the freeze holds a zero word instead of stale data. The stimulus drops reset a few nanoseconds after an edge and checks the outputs before the next edge. It keeps the gating inputs high through the release and one more edge, and only then lowers `gateEn` to show the first real load. The table walk covers the same-edge rule of R10. In that row both chip selects turn high at the same edge as a new data value, and the old value must remain.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;  // capture the data word at the next edge
    logic mapSwap;   // second copy uses the half-exchanged lane map
  } rbufStrobes_t;

endpackage

// File: rtl/rbuf_ctrl.sv
module rbuf_ctrl
  import rbuf_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            gateEn,
  input  logic [CS_W-1:0] csIn,
  input  logic            cfgSel,
  output rbufStrobes_t    strobes
);

  logic allDeselected;

  // The freeze needs every chip select high at the sampling edge
  assign allDeselected = &csIn;

  always_comb begin
    strobes.loadData = !(gateEn && allDeselected);
    strobes.mapSwap  = cfgSel;
  end

endmodule

// File: rtl/rbuf_datapath.sv
module rbuf_datapath
  import rbuf_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbufStrobes_t      strobes,
  input  logic [DATA_W-1:0] dIn,
  input  logic [CS_W-1:0]   csIn,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB,
  output logic [CS_W-1:0]   csQA,
  output logic [CS_W-1:0]   csQB
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] wordQ;
  logic [DATA_W-1:0] wordSwapped;
  logic [CS_W-1:0]   csQ;

  // Data register: loads only when the control allows it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobes.loadData) begin
      wordQ <= dIn;
    end
  end

  // Chip-select register: loads on every edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= '0;
    end else begin
      csQ <= csIn;
    end
  end

  // Map B lane order: the two halves are exchanged
  for (genvar i = 0; i < DATA_W; i++) begin : g_swap
    assign wordSwapped[i] = wordQ[(i + HALF) % DATA_W];
  end

  assign qA   = wordQ;
  assign qB   = strobes.mapSwap ? wordSwapped : wordQ;
  assign csQA = csQ;
  assign csQB = csQ;

endmodule

// File: rtl/rbuf_gated_fanout.sv
module rbuf_gated_fanout
  import rbuf_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSel,
  input  logic              gateEn,
  input  logic [CS_W-1:0]   csIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB,
  output logic [CS_W-1:0]   csQA,
  output logic [CS_W-1:0]   csQB
);

  rbufStrobes_t strobes;

  rbuf_ctrl #(.CS_W(CS_W)) u_ctrl (
    .gateEn (gateEn),
    .csIn   (csIn),
    .cfgSel (cfgSel),
    .strobes(strobes)
  );

  rbuf_datapath #(.DATA_W(DATA_W), .CS_W(CS_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dIn    (dIn),
    .csIn   (csIn),
    .qA     (qA),
    .qB     (qB),
    .csQA   (csQA),
    .csQB   (csQB)
  );

endmodule

// File: rtl/rbuf_checker.sv
module rbuf_checker #(
  parameter int DATA_W = 28,
  parameter int CS_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgSel,
  input logic              gateEn,
  input logic [CS_W-1:0]   csIn,
  input logic [DATA_W-1:0] dIn,
  input logic [DATA_W-1:0] qA,
  input logic [DATA_W-1:0] qB,
  input logic [CS_W-1:0]   csQA,
  input logic [CS_W-1:0]   csQB
);

  localparam int HALF = DATA_W / 2;

  logic frozen;
  assign frozen = gateEn && (&csIn);

  // R1: outputs are zero whenever reset is seen low at an edge
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (qA == '0 && qB == '0 && csQA == '0 && csQB == '0)
        else $error("reset did not clear outputs");
    end
  end

  // R2, R7: an unfrozen edge loads the data word
  p_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frozen |=> qA == $past(dIn));

  // R6, R10: a frozen edge keeps the data outputs
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> ($stable(qA) && $stable(qB)));

  // R4: map A copies are identical
  p_copy_same_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSel |-> qB == qA);

  // R5: map B exchanges the halves
  p_copy_swap_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |-> qB == {qA[HALF-1:0], qA[DATA_W-1:HALF]});

  // R8: chip selects always pass through on both copies
  p_cs_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (csQA == $past(csIn) && csQB == $past(csIn)));

endmodule

bind rbuf_gated_fanout rbuf_checker #(.DATA_W(DATA_W), .CS_W(CS_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .cfgSel(cfgSel),
  .gateEn(gateEn),
  .csIn  (csIn),
  .dIn   (dIn),
  .qA    (qA),
  .qB    (qB),
  .csQA  (csQA),
  .csQB  (csQB)
);

// File: tb/sim_rbuf_gated_fanout.sv
`timescale 1ns/1ps
module sim_rbuf_gated_fanout;

  localparam int DATA_W = 28;
  localparam int CS_W   = 2;
  localparam int NVEC   = 10;

  // {cfgSel, gateEn, csIn[1], csIn[0], dIn[27:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00ABCDEF,  // plain load, map A
    32'h41234567,  // R7: gate on, both chip selects low
    32'h67654321,  // R7: gate on, one chip select low
    32'h7FFFFFFF,  // R10: chip selects turn high at this edge -> hold
    32'h75555555,  // R6: still frozen
    32'h32AAAAAA,  // R7: gate off, chip selects high -> load
    32'h90003FFF,  // R5: map B load
    32'hFC000001,  // R6: frozen in map B
    32'hD8000000,  // R7: map B load
    32'h00000000   // back to map A
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgSel = 1'b0;
  logic              gateEn = 1'b0;
  logic [CS_W-1:0]   csIn = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] qA, qB;
  logic [CS_W-1:0]   csQA, csQB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rbuf_gated_fanout #(.DATA_W(DATA_W), .CS_W(CS_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .gateEn(gateEn),
    .csIn(csIn), .dIn(dIn), .qA(qA), .qB(qB), .csQA(csQA), .csQB(csQB)
  );

  function automatic logic [DATA_W-1:0] halfSwap(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = w[(i + DATA_W/2) % DATA_W];
    return r;
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] model;
    model = '0;

    // Reset state, R1
    #1;
    chk("R1 qA", qA, '0);
    chk("R1 qB", qB, '0);
    chk("R1 csQA", {26'd0, csQA}, '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table walk
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      cfgSel = VEC[k][31];
      gateEn = VEC[k][30];
      csIn   = VEC[k][29:28];
      dIn    = VEC[k][27:0];
      @(posedge clk);
      #2;
      if (!(VEC[k][30] && VEC[k][29] && VEC[k][28])) model = VEC[k][27:0];
      chk("R3 qA", qA, model);
      if (VEC[k][31]) chk("R5 qB", qB, halfSwap(model));
      else            chk("R4 qB", qB, model);
      chk("R8 csQA", {26'd0, csQA}, {26'd0, VEC[k][29:28]});
      chk("R8 csQB", {26'd0, csQB}, {26'd0, VEC[k][29:28]});
    end

    // R2: dIn moving between edges does not reach the outputs
    @(negedge clk);
    gateEn = 1'b0; csIn = 2'b00; cfgSel = 1'b0; dIn = 28'h0F0F0F0;
    @(posedge clk); #2;
    chk("R2 load", qA, 28'h0F0F0F0);
    @(negedge clk);
    dIn = 28'h1234ABC;
    #1;
    chk("R2 between edges", qA, 28'h0F0F0F0);

    // R1: asynchronous reset in mid-phase
    @(posedge clk); #3;
    rstN = 1'b0;
    #1;
    chk("R1 async qA", qA, '0);
    chk("R1 async qB", qB, '0);
    chk("R1 async csQB", {26'd0, csQB}, '0);

    // R9: reset held across an edge while frozen, release while frozen
    @(negedge clk);
    gateEn = 1'b1; csIn = 2'b11; dIn = 28'hABCDEF1;
    @(posedge clk); #2;
    chk("R9 reset over gating", qA, '0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R9 after release", qA, '0);
    @(posedge clk); #2;
    chk("R9 frozen after release", qA, '0);
    chk("R9 frozen after release qB", qB, '0);
    @(negedge clk);
    gateEn = 1'b0; dIn = 28'h1111111;
    @(posedge clk); #2;
    chk("R9 first load", qA, 28'h1111111);
    chk("R8 cs while loading", {26'd0, csQA}, 28'd3);

    summary();
  end

endmodule